// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a multicycle processor, built as a small stored-program machine. A micro-program counter selects one microword from a writable control store every clock. The upper sixteen bits of that word drive the datapath control lines directly. The lowest two bits say where the next microword comes from. The options are the fetch word at address zero, the following address, or one of two lookup tables indexed by the 6-bit opcode held in the instruction register.

The control store and both lookup tables are loaded through a write port. That port is only honoured while the load-hold input keeps the sequencer parked at address zero. Once hold is released, each microinstruction lasts exactly one cycle. Lookup entries that were never written read as zero, so an opcode with no microprogram falls straight back to fetch.

Top module: `mseq_top`

## Requirements
- R1: After reset the micro-program counter is 0, every control store word and every lookup entry is 0, and so the control output reads 0.
- R2: When the sequencing field (microword bits 1:0) is 2'b11, the counter advances by one on the next clock, wrapping from 15 to 0.
- R3: When the sequencing field is 2'b00, the next address is 0.
- R4: When the sequencing field is 2'b01, the next address is the entry of lookup table one indexed by the opcode input.
- R5: When the sequencing field is 2'b10, the next address is the entry of lookup table two indexed by the opcode input.
- R6: The control output equals bits 17:2 of the control store word at the current counter value, combinationally.
- R7: A write with hold high and we high is steered by the select input: 0 writes the control store (address bits 3:0, all 18 data bits); 1 writes lookup table one and 2 writes lookup table two (6-bit address, data bits 3:0). Select 3 changes nothing.
- R8: While hold is high, the counter is forced to 0 on each clock. Writes presented while hold is low are ignored.
- R9: An opcode whose lookup entry was never written dispatches to address 0.
- R10: With the ten-word microprogram loaded, the address traces run as follows, with fetch at 0 and decode at 1. Load: 0,1,2,3,4,0. Store: 0,1,2,5,0. Register op: 0,1,6,7,0. Branch: 0,1,8,0. Jump: 0,1,9,0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears counter and all tables |
| ld_hold | input | 1 | Parks the counter at 0 and enables table writes |
| ld_we | input | 1 | Write strobe for the load port |
| ld_sel | input | 2 | Write target: 0 control store, 1 table one, 2 table two, 3 none |
| ld_addr | input | 6 | Write address |
| ld_data | input | 18 | Write data |
| opcode | input | 6 | Opcode from the instruction register, indexes both tables |
| upc | output | 4 | Current micro-program counter |
| ctrl | output | 16 | Datapath control signals of the current microword |

## Verification
The next-address properties assume that the opcode and the table contents seen in a cycle are the ones that steer the following edge. They also assume that hold overrides every sequencing code. The checker therefore samples the lookup outputs themselves rather than the opcode. The stimulus changes the opcode, hold and the write port only on falling edges. Every table is loaded before hold is released. Run-time write attempts are made only while the addressed word is not the one being observed.

// File: rtl/mseq_pkg.sv
`timescale 1ns/1ps
package mseq_pkg;
   // next-address selection, bits 1:0 of every microword
   typedef enum logic [1:0] {
      SEQ_FETCH = 2'b00,
      SEQ_DISP1 = 2'b01,
      SEQ_DISP2 = 2'b10,
      SEQ_INCR  = 2'b11
   } seq_code_e;

   // target of the load port
   typedef enum logic [1:0] {
      LD_CSTORE = 2'b00,
      LD_DISP1  = 2'b01,
      LD_DISP2  = 2'b10,
      LD_NONE   = 2'b11
   } ld_sel_e;

   localparam int SEQ_W  = 2;
   localparam int N_DISP = 2;
endpackage

// File: rtl/mseq_table.sv
`timescale 1ns/1ps
// Generic writable table with combinational read, cleared by reset.
module mseq_table #(
   parameter int AW    = 4,
   parameter int DW    = 18,
   parameter int DEPTH = 1 << AW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   if (DEPTH > (1 << AW) || DEPTH < 1) begin : g_bad_depth
      $error("mseq_table: DEPTH does not fit the address width");
   end

   logic [DW-1:0] mem_q [DEPTH];

   for (genvar r = 0; r < DEPTH; r++) begin : g_row
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      mem_q[r] <= '0;
         else if (we && waddr == AW'(r))  mem_q[r] <= wdata;
      end
   end

   assign rdata = mem_q[raddr];
endmodule

// File: rtl/mseq_next.sv
`timescale 1ns/1ps
// Four-way next micro-address selection with incrementer.
module mseq_next
   import mseq_pkg::*;
#(
   parameter int AW = 4
) (
   input  logic          hold,
   input  seq_code_e     seq,
   input  logic [AW-1:0] cur,
   input  logic [AW-1:0] disp1,
   input  logic [AW-1:0] disp2,
   output logic [AW-1:0] nxt
);
   logic [AW-1:0] inc;
   assign inc = AW'(cur + 1'b1);

   always_comb begin
      if (hold) nxt = '0;
      else begin
         unique case (seq)
            SEQ_FETCH: nxt = '0;
            SEQ_DISP1: nxt = disp1;
            SEQ_DISP2: nxt = disp2;
            SEQ_INCR:  nxt = inc;
            default:   nxt = '0;
         endcase
      end
   end
endmodule

// File: rtl/mseq_top.sv
`timescale 1ns/1ps
module mseq_top
   import mseq_pkg::*;
#(
   parameter int UPC_W  = 4,
   parameter int CTRL_W = 16,
   parameter int OP_W   = 6,
   localparam int WORD_W = CTRL_W + SEQ_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_hold,
   input  logic              ld_we,
   input  logic [1:0]        ld_sel,
   input  logic [OP_W-1:0]   ld_addr,
   input  logic [WORD_W-1:0] ld_data,
   input  logic [OP_W-1:0]   opcode,
   output logic [UPC_W-1:0]  upc,
   output logic [CTRL_W-1:0] ctrl
);
   if (UPC_W < 2 || UPC_W > 8) begin : g_bad_upc
      $error("mseq_top: UPC_W out of range");
   end
   if (UPC_W > OP_W) begin : g_bad_addr
      $error("mseq_top: load address narrower than micro-address");
   end
   if (OP_W > 8) begin : g_bad_op
      $error("mseq_top: opcode tables too deep");
   end

   logic [UPC_W-1:0]  upc_q, upc_d;
   logic [WORD_W-1:0] word;
   logic [UPC_W-1:0]  disp_q [N_DISP];
   logic [UPC_W-1:0]  disp1_q, disp2_q;
   seq_code_e         seq_code;
   logic              ld_ok;

   assign ld_ok = ld_hold & ld_we;

   mseq_table #(.AW(UPC_W), .DW(WORD_W)) u_cstore (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (ld_ok && ld_sel == LD_CSTORE),
      .waddr (ld_addr[UPC_W-1:0]),
      .wdata (ld_data),
      .raddr (upc_q),
      .rdata (word)
   );

   for (genvar g = 0; g < N_DISP; g++) begin : g_disp
      mseq_table #(.AW(OP_W), .DW(UPC_W)) u_disp (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (ld_ok && ld_sel == 2'(g + 1)),
         .waddr (ld_addr),
         .wdata (ld_data[UPC_W-1:0]),
         .raddr (opcode),
         .rdata (disp_q[g])
      );
   end

   assign disp1_q  = disp_q[0];
   assign disp2_q  = disp_q[1];
   assign seq_code = seq_code_e'(word[SEQ_W-1:0]);

   mseq_next #(.AW(UPC_W)) u_next (
      .hold  (ld_hold),
      .seq   (seq_code),
      .cur   (upc_q),
      .disp1 (disp1_q),
      .disp2 (disp2_q),
      .nxt   (upc_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) upc_q <= '0;
      else        upc_q <= upc_d;
   end

   assign upc  = upc_q;
   assign ctrl = word[WORD_W-1:SEQ_W];
endmodule

// File: rtl/mseq_chk.sv
`timescale 1ns/1ps
module mseq_chk #(
   parameter int UPC_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ld_hold,
   input logic [UPC_W-1:0] upc,
   input logic [1:0]       seq,
   input logic [UPC_W-1:0] disp1,
   input logic [UPC_W-1:0] disp2
);
   // R8
   hold_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_hold |=> upc == '0);

   // R3
   fetch_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_hold && seq == 2'b00) |=> upc == '0);

   // R2
   incr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_hold && seq == 2'b11) |=> upc == UPC_W'($past(upc) + 1'b1));

   // R4
   disp_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_hold && seq == 2'b01) |=> upc == $past(disp1));

   // R5
   disp_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_hold && seq == 2'b10) |=> upc == $past(disp2));
endmodule

bind mseq_top mseq_chk #(.UPC_W(UPC_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .ld_hold (ld_hold),
   .upc     (upc),
   .seq     (word[1:0]),
   .disp1   (disp1_q),
   .disp2   (disp2_q)
);

// File: tb/mseq_top_bench.sv
`timescale 1ns/1ps
module mseq_top_bench;
   logic        clk = 1'b0, rst_n = 1'b0;
   logic        ld_hold = 1'b0, ld_we = 1'b0;
   logic [1:0]  ld_sel = 2'd0;
   logic [5:0]  ld_addr = '0, opcode = '0;
   logic [17:0] ld_data = '0;
   logic [3:0]  upc;
   logic [15:0] ctrl;
   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   mseq_top u_mseq_top (
      .clk(clk), .rst_n(rst_n), .ld_hold(ld_hold), .ld_we(ld_we),
      .ld_sel(ld_sel), .ld_addr(ld_addr), .ld_data(ld_data),
      .opcode(opcode), .upc(upc), .ctrl(ctrl)
   );

   // microprogram as the bench expects it
   function automatic logic [17:0] mword(int s);
      logic [1:0] sq;
      case (s)
         0: return 18'h0228B;
         1: return 18'h06001;
         2: sq = 2'b10;
         3, 6, 15: sq = 2'b11;
         default: sq = 2'b00;
      endcase
      return {16'hA500 | 16'(s), sq};
   endfunction

   task automatic chk(string rq, string what, int got, int exp);
      checks++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s %s: got %0h expected %0h", rq, what, got, exp);
      end
   endtask

   task automatic wr(logic [1:0] sel, logic [5:0] a, logic [17:0] d);
      @(negedge clk);
      ld_hold = 1'b1; ld_we = 1'b1; ld_sel = sel; ld_addr = a; ld_data = d;
      @(negedge clk);
      ld_we = 1'b0;
   endtask

   // opcode, trace length, trace (state k in bits 4k+3:4k), requirement id
   typedef struct packed {
      logic [5:0]  op;
      logic [2:0]  n;
      logic [23:0] tr;
      logic [3:0]  rq;
   } vec_t;

   localparam vec_t VECS [7] = '{
      '{6'd35, 3'd6, 24'h043210, 4'd10},  // R10 load
      '{6'd43, 3'd5, 24'h005210, 4'd10},  // R10 store
      '{6'd0,  3'd5, 24'h007610, 4'd10},  // R10 register op
      '{6'd4,  3'd4, 24'h000810, 4'd10},  // R10 branch
      '{6'd2,  3'd4, 24'h000910, 4'd10},  // R10 jump
      '{6'd63, 3'd3, 24'h000010, 4'd9},   // R9 unprogrammed opcode
      '{6'd62, 3'd5, 24'h010F10, 4'd2}    // R2 wrap 15 -> 0
   };

   function automatic string rq_name(logic [3:0] r);
      case (r)
         4'd2:  return "R2";
         4'd9:  return "R9";
         default: return "R10";
      endcase
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1", "upc after reset", upc, 0);
      chk("R1", "ctrl after reset", ctrl, 0);
      @(negedge clk); #1;
      chk("R3", "upc stays at 0 on zero word", upc, 0);

      for (int s = 0; s < 10; s++) wr(2'd0, 6'(s), mword(s));
      wr(2'd0, 6'd15, mword(15));
      wr(2'd1, 6'd35, 18'd2); wr(2'd1, 6'd43, 18'd2);
      wr(2'd1, 6'd0,  18'd6); wr(2'd1, 6'd4,  18'd8);
      wr(2'd1, 6'd2,  18'd9); wr(2'd1, 6'd62, 18'd15);
      wr(2'd2, 6'd35, 18'd3); wr(2'd2, 6'd43, 18'd5);
      #1;
      chk("R7", "ctrl of loaded fetch word", ctrl, 32'(mword(0) >> 2));
      chk("R8", "upc parked during load", upc, 0);
      wr(2'd3, 6'd0, 18'h3FFFF);   // select 3: no target
      #1;
      chk("R7", "select 3 leaves store intact", ctrl, 32'(mword(0) >> 2));

      for (int v = 0; v < 7; v++) begin
         @(negedge clk);
         ld_hold = 1'b1; opcode = VECS[v].op;
         @(negedge clk);
         ld_hold = 1'b0;
         for (int k = 0; k < int'(VECS[v].n); k++) begin
            #1;
            chk(rq_name(VECS[v].rq), "upc trace", upc, int'(VECS[v].tr[4*k +: 4]));
            chk("R6", "ctrl of current word", ctrl,
                32'(mword(int'(VECS[v].tr[4*k +: 4])) >> 2));
            @(negedge clk);
         end
      end

      // R5 direct: load and store take different second dispatches
      // R8: write while running is ignored
      @(negedge clk);
      ld_hold = 1'b1; opcode = 6'd0;
      @(negedge clk);
      ld_hold = 1'b0; ld_we = 1'b1; ld_sel = 2'd0; ld_addr = 6'd1; ld_data = 18'h3FFFF;
      #1;
      chk("R8", "upc at fetch", upc, 0);
      @(negedge clk);
      ld_we = 1'b0;
      #1;
      chk("R8", "upc at decode", upc, 1);
      chk("R8", "decode word not overwritten while running", ctrl, 32'(mword(1) >> 2));
      @(negedge clk);
      #1;
      chk("R4", "register op dispatch", upc, 6);
      ld_hold = 1'b1;
      @(negedge clk); #1;
      chk("R8", "hold mid-program returns to 0", upc, 0);
      @(negedge clk); #1;
      chk("R8", "hold keeps upc at 0", upc, 0);
      ld_hold = 1'b0; opcode = 6'd43;
      repeat (3) @(negedge clk);
      #1;
      chk("R5", "store second dispatch", upc, 5);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule